// File: doc/BRIEF.md
# Stalling Host Bus Slave

This block sits on a clocked, 16-bit, generic microprocessor bus and answers one access at a time. An access opens on the first rising bus-clock edge at which the active-low chip select is low together with either the active-low read strobe or the active-low write strobe. At that edge the block captures the 17-bit address, the space select (memory or register), the active-low upper-byte enable and a 2-bit clock-ratio code. It then drives its active-low wait line low for a fixed number of bus clocks chosen by that code.

During a write, the block takes the data bus into a write buffer on the third rising edge of the access. It commits the enabled byte lanes to an internal store at the edge where the wait line is released. During a read, the block drives the data bus from the cycle after the opening edge and holds the stored word there until the strobe rises. Output enables for the wait line and the data bus stand in for the tri-state pads.

When the strobe rises, the block returns to idle. If chip select or the strobe goes high while the wait line is still low, the access is dropped and nothing is written.

Top module: `hbus_slave`

## Requirements
- R1: While reset is high and on the cycle after it, wait_oe=0, wait_n=1 and dout_oe=0. Every word of both storage spaces reads back as 0x0000 after reset.
- R2: An access starts at the first rising edge with cs_n=0 and (rd_n=0 or we_n=0). It is a write when we_n=0 at that edge and a read otherwise. From the next cycle wait_oe=1 and wait_n=0. At that edge the block samples addr, mr_sel, bhe_n and div_sel, and it ignores later changes to them.
- R3: wait_n stays low for exactly N consecutive cycles. N is 8 for div_sel=00, 13 for 01, 15 for 10 and 21 for 11. After that, wait_n=1 with wait_oe=1 until the strobe rise is seen.
- R4: When wait_n is high and a rising edge sees rd_n=1 and we_n=1, the next cycle has wait_oe=0 and dout_oe=0. A new access may start at the following edge.
- R5: Write data is sampled on the third rising edge of the access, counting the opening edge as the first. Values on din after that edge have no effect on the stored word.
- R6: The low byte (bits 7:0) is written only when addr[0]=0. The high byte (bits 15:8) is written only when bhe_n=0. A disabled lane keeps its old value.
- R7: mr_sel=1 selects a 64-word memory indexed by addr[6:1]. mr_sel=0 selects an 8-word register space indexed by addr[3:1]. A write to one space never changes the other.
- R8: In a read, dout_oe=1 from the cycle after the opening edge until the strobe rise is seen. Throughout that time dout carries the full 16-bit word stored at the sampled index, whatever the byte enables.
- R9: If a rising edge during the stall sees cs_n=1, or sees both strobes high, the next cycle has wait_oe=0 and dout_oe=0, and no write is committed.
- R10: A write is committed at the edge where wait_n is released. A write access never raises dout_oe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| bhe_n | input | 1 | Upper byte enable, active low |
| mr_sel | input | 1 | Space select: 1 memory, 0 register |
| addr | input | 17 | Byte address |
| din | input | 16 | Write data from the bus |
| div_sel | input | 2 | Clock ratio code (00 1:1, 01 /2, 10 /3, 11 /4) |
| wait_n | output | 1 | Wait line value, active low |
| wait_oe | output | 1 | Output enable of the wait line |
| dout | output | 16 | Read data to the bus |
| dout_oe | output | 1 | Output enable of the data bus |

## Verification
The embedded assertions check, on every cycle, the relations between the control flops. The data output is never enabled without the wait line, a write never enables the data output, and the stall counter never passes its limit. A strobe rise or a chip-select drop always clears both enables on the next cycle, and the wait line is always released at the counted edge. Only the bench's scenarios can show the exact stall length for each ratio code and the moment write data is taken. They also show the byte-lane merge results and the separation of the two spaces, and that an aborted write leaves the stored word untouched. The bench shows these by reading the stores back through ordinary bus accesses.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int ADDR_W     = 17;
    localparam int DATA_W     = 16;
    localparam int LANES      = DATA_W / 8;
    localparam int CNT_W      = 5;
    localparam int LATCH_EDGE = 3;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_STALL = 2'd1,
        ST_READY = 2'd2
    } hbus_state_e;

    typedef struct packed {
        logic              wr;
        logic              mr;
        logic [ADDR_W-1:0] addr;
        logic [LANES-1:0]  be;
        logic [1:0]        div;
    } hbus_req_t;

    function automatic logic [CNT_W-1:0] stall_cycles(input logic [1:0] code);
        logic [CNT_W-1:0] n;
        case (code)
            2'b00:   n = CNT_W'(8);
            2'b01:   n = CNT_W'(13);
            2'b10:   n = CNT_W'(15);
            default: n = CNT_W'(21);
        endcase
        return n;
    endfunction

    function automatic logic [LANES-1:0] lane_enables(input logic a0, input logic bhe_n);
        logic [LANES-1:0] be;
        be    = '0;
        be[0] = ~a0;
        be[LANES-1] = ~bhe_n;
        return be;
    endfunction

endpackage

// File: rtl/hbus_wait_timer.sv
module hbus_wait_timer
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             run,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] tick
);
    logic [CNT_W-1:0] elapsed_q;

    always_ff @(posedge clk) begin
        if (rst || start) begin
            elapsed_q <= '0;
        end else if (run && (elapsed_q != limit)) begin
            elapsed_q <= elapsed_q + CNT_W'(1);
        end
    end

    // number of the edge about to occur, counting the opening edge as 0
    assign tick = elapsed_q + CNT_W'(1);

    p_tick_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (elapsed_q <= limit));

endmodule

// File: rtl/hbus_wbuf.sv
module hbus_wbuf
    import hbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              capture,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] data,
    output logic              valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            data  <= '0;
            valid <= 1'b0;
        end else if (clear) begin
            valid <= 1'b0;
        end else if (capture) begin
            data  <= din;
            valid <= 1'b1;
        end
    end

    p_capture_once_r5: assert property (@(posedge clk) disable iff (rst)
        (valid && !clear) |-> !capture);

endmodule

// File: rtl/hbus_store.sv
module hbus_store
    import hbus_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int REG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_mr,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_mr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int MEM_IW = (MEM_WORDS > 2) ? $clog2(MEM_WORDS) : 1;
    localparam int REG_IW = (REG_WORDS > 2) ? $clog2(REG_WORDS) : 1;

    logic [MEM_IW-1:0] w_mi, r_mi;
    logic [REG_IW-1:0] w_ri, r_ri;

    assign w_mi = wr_addr[MEM_IW:1];
    assign r_mi = rd_addr[MEM_IW:1];
    assign w_ri = wr_addr[REG_IW:1];
    assign r_ri = rd_addr[REG_IW:1];

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [7:0] mem_b [MEM_WORDS];
        logic [7:0] reg_b [REG_WORDS];

        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < MEM_WORDS; i++) mem_b[i] <= '0;
                for (int i = 0; i < REG_WORDS; i++) reg_b[i] <= '0;
            end else if (wr_en && wr_be[l]) begin
                if (wr_mr) mem_b[w_mi] <= wr_data[l*8 +: 8];
                else       reg_b[w_ri] <= wr_data[l*8 +: 8];
            end
        end

        assign rd_data[l*8 +: 8] = rd_mr ? mem_b[r_mi] : reg_b[r_ri];
    end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
    import hbus_pkg::*;
#(
    parameter int MEM_WORDS = 64,
    parameter int REG_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              we_n,
    input  logic              bhe_n,
    input  logic              mr_sel,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        div_sel,
    output logic              wait_n,
    output logic              wait_oe,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam logic [CNT_W-1:0] LATCH_TICK = CNT_W'(LATCH_EDGE - 1);

    hbus_state_e      state_q, state_d;
    hbus_req_t        req_q;
    logic [CNT_W-1:0] tick, limit;
    logic             strobe_low, hold_ok, start, in_stall, release_now;
    logic             capture, commit, wb_valid;
    logic [DATA_W-1:0] wb_data, rd_word;

    assign strobe_low  = !rd_n || !we_n;
    assign hold_ok     = !cs_n && strobe_low;
    assign start       = (state_q == ST_IDLE) && hold_ok;
    assign in_stall    = (state_q == ST_STALL);
    assign limit       = stall_cycles(req_q.div);
    assign release_now = in_stall && hold_ok && (tick == limit);
    assign capture     = in_stall && hold_ok && req_q.wr && !we_n && (tick == LATCH_TICK);
    assign commit      = release_now && req_q.wr && wb_valid;

    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (hold_ok) state_d = ST_STALL;
            ST_STALL: begin
                if (!hold_ok)         state_d = ST_IDLE;
                else if (release_now) state_d = ST_READY;
            end
            ST_READY: if (!hold_ok) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            req_q   <= '0;
        end else begin
            state_q <= state_d;
            if (start) begin
                req_q.wr   <= !we_n;
                req_q.mr   <= mr_sel;
                req_q.addr <= addr;
                req_q.be   <= lane_enables(addr[0], bhe_n);
                req_q.div  <= div_sel;
            end
        end
    end

    // pad-side flops
    always_ff @(posedge clk) begin
        if (rst) begin
            wait_oe <= 1'b0;
            wait_n  <= 1'b1;
            dout_oe <= 1'b0;
            dout    <= '0;
        end else begin
            wait_oe <= (state_d != ST_IDLE);
            wait_n  <= (state_d != ST_STALL);
            if (start) begin
                dout_oe <= we_n;
                dout    <= rd_word;
            end else if (state_d == ST_IDLE) begin
                dout_oe <= 1'b0;
            end
        end
    end

    hbus_wait_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .run   (in_stall),
        .limit (limit),
        .tick  (tick)
    );

    hbus_wbuf u_wbuf (
        .clk     (clk),
        .rst     (rst),
        .clear   (start),
        .capture (capture),
        .din     (din),
        .data    (wb_data),
        .valid   (wb_valid)
    );

    hbus_store #(
        .MEM_WORDS (MEM_WORDS),
        .REG_WORDS (REG_WORDS)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (commit),
        .wr_mr   (req_q.mr),
        .wr_addr (req_q.addr),
        .wr_be   (req_q.be),
        .wr_data (wb_data),
        .rd_mr   (mr_sel),
        .rd_addr (addr),
        .rd_data (rd_word)
    );

    p_dout_needs_wait_r8: assert property (@(posedge clk) disable iff (rst)
        dout_oe |-> wait_oe);

    p_write_no_dout_r10: assert property (@(posedge clk) disable iff (rst)
        (wait_oe && req_q.wr) |-> !dout_oe);

    p_release_r3: assert property (@(posedge clk) disable iff (rst)
        release_now |=> (wait_n && wait_oe));

    p_strobe_rise_r4: assert property (@(posedge clk) disable iff (rst)
        (wait_oe && rd_n && we_n) |=> (!wait_oe && !dout_oe));

    p_cs_abort_r9: assert property (@(posedge clk) disable iff (rst)
        (wait_oe && cs_n) |=> (!wait_oe && !dout_oe));

    p_commit_window_r10: assert property (@(posedge clk) disable iff (rst)
        commit |-> (!wait_n && wait_oe && !cs_n));

    p_wait_low_driven_r2: assert property (@(posedge clk) disable iff (rst)
        !wait_n |-> wait_oe);

endmodule

// File: tb/hbus_slave_bench.sv
module hbus_slave_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, rd_n = 1'b1, we_n = 1'b1, bhe_n = 1'b1, mr_sel = 1'b0;
    logic [16:0] addr = '0;
    logic [15:0] din = '0;
    logic [1:0]  div_sel = '0;
    logic        wait_n, wait_oe, dout_oe;
    logic [15:0] dout;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    hbus_slave u_hbus_slave (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n),
        .bhe_n(bhe_n), .mr_sel(mr_sel), .addr(addr), .din(din),
        .div_sel(div_sel), .wait_n(wait_n), .wait_oe(wait_oe),
        .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_mem [64];
    logic [15:0] m_reg [8];
    int          m_phase;   // 0 idle, 1 stalling, 2 released
    int          m_edges, m_len;
    bit          m_wr, m_mr, m_lo, m_hi, m_bufv;
    int          m_idx;
    logic [15:0] m_buf;
    bit          e_woe, e_wn, e_doe;
    logic [15:0] e_dout;

    function automatic int ratio_len(input logic [1:0] c);
        if (c == 2'd0) return 8;
        if (c == 2'd1) return 13;
        if (c == 2'd2) return 15;
        return 21;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) m_mem[i] = 16'h0;
            for (int i = 0; i < 8; i++)  m_reg[i] = 16'h0;
            m_phase = 0; m_bufv = 0; e_dout = 16'h0;
        end else begin
            bit active;
            active = !cs_n && (!rd_n || !we_n);
            if (m_phase == 0) begin
                if (active) begin
                    m_phase = 1; m_edges = 0; m_len = ratio_len(div_sel);
                    m_wr = !we_n; m_mr = mr_sel; m_lo = !addr[0]; m_hi = !bhe_n;
                    m_idx = m_mr ? int'(addr[6:1]) : int'(addr[3:1]);
                    m_bufv = 0;
                    if (!m_wr) e_dout = m_mr ? m_mem[m_idx] : m_reg[m_idx];
                end
            end else if (!active) begin
                m_phase = 0;
            end else if (m_phase == 1) begin
                m_edges++;
                if (m_edges == 2 && m_wr && !we_n) begin m_buf = din; m_bufv = 1; end
                if (m_edges == m_len) begin
                    m_phase = 2;
                    if (m_wr && m_bufv) begin
                        logic [15:0] w;
                        w = m_mr ? m_mem[m_idx] : m_reg[m_idx];
                        if (m_lo) w[7:0]  = m_buf[7:0];
                        if (m_hi) w[15:8] = m_buf[15:8];
                        if (m_mr) m_mem[m_idx] = w; else m_reg[m_idx] = w;
                    end
                end
            end
        end
        e_woe = (m_phase != 0);
        e_wn  = (m_phase != 1);
        e_doe = (m_phase != 0) && !m_wr;
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (!rst && cycles > 2) begin
            check(wait_oe == e_woe, "R2 wait_oe", wait_oe, e_woe);
            check(wait_n  == e_wn,  "R3 wait_n",  wait_n,  e_wn);
            check(dout_oe == e_doe, "R8 dout_oe", dout_oe, e_doe);
            if (e_doe) check(dout == e_dout, "R8 dout", dout, e_dout);
        end
        if (cycles > 20000) begin
            check(1'b0, "watchdog", cycles, 20000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic access(input bit wr, input bit mr, input logic [16:0] a, input bit bh,
                          input logic [15:0] d, input logic [1:0] dv,
                          output int lows, output logic [15:0] rd);
        @(negedge clk);
        cs_n = 1'b0; mr_sel = mr; addr = a; bhe_n = bh; div_sel = dv; din = d;
        if (wr) we_n = 1'b0; else rd_n = 1'b0;
        lows = 0; rd = 16'h0;
        for (int k = 1; k < 60; k++) begin
            @(negedge clk);
            if (k == 1) begin
                rd = dout;
                // R2: sampled fields must no longer matter
                mr_sel = ~mr; addr = ~a; bhe_n = ~bh; div_sel = ~dv;
            end
            if (k == 3) din = ~d;  // R5: after the third edge
            if (wait_n) break;
            lows++;
        end
        @(negedge clk);
        rd_n = 1'b1; we_n = 1'b1;
        @(negedge clk);
        check(!wait_oe && !dout_oe, "R4 enables off after strobe rise", {wait_oe, dout_oe}, 0);
        cs_n = 1'b1;
    endtask

    task automatic aborted_write(input bit mr, input logic [16:0] a, input logic [15:0] d);
        @(negedge clk);
        cs_n = 1'b0; mr_sel = mr; addr = a; bhe_n = 1'b0; div_sel = 2'd0; din = d; we_n = 1'b0;
        repeat (5) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        check(!wait_oe && !dout_oe, "R9 abort drops enables", {wait_oe, dout_oe}, 0);
        we_n = 1'b1;
    endtask

    initial begin
        int n;
        logic [15:0] r;
        repeat (3) @(negedge clk);
        check(!wait_oe && wait_n && !dout_oe, "R1 reset outputs", {wait_oe, wait_n, dout_oe}, 3'b010);
        rst = 1'b0;
        @(negedge clk);
        check(!wait_oe && wait_n && !dout_oe, "R1 after reset", {wait_oe, wait_n, dout_oe}, 3'b010);

        access(0, 1, 17'h4, 0, 16'h0, 2'd0, n, r);
        check(n == 8, "R3 div 00 length", n, 8);
        check(r == 16'h0, "R1 memory cleared", r, 0);

        access(1, 1, 17'h4, 0, 16'h1234, 2'd1, n, r);
        check(n == 13, "R3 div 01 length", n, 13);
        access(1, 1, 17'h5, 0, 16'hAB00, 2'd2, n, r);
        check(n == 15, "R3 div 10 length", n, 15);
        access(1, 1, 17'h4, 1, 16'h00CD, 2'd3, n, r);
        check(n == 21, "R3 div 11 length", n, 21);
        access(0, 1, 17'h4, 0, 16'h0, 2'd0, n, r);
        check(r == 16'hABCD, "R6 R5 merged lanes", r, 16'hABCD);

        access(1, 0, 17'h4, 0, 16'h5555, 2'd0, n, r);
        access(0, 0, 17'h4, 0, 16'h0, 2'd0, n, r);
        check(r == 16'h5555, "R7 register space", r, 16'h5555);
        access(0, 1, 17'h4, 1, 16'h0, 2'd1, n, r);
        check(r == 16'hABCD, "R7 memory untouched", r, 16'hABCD);

        aborted_write(1, 17'h4, 16'h0000);
        access(0, 1, 17'h4, 0, 16'h0, 2'd0, n, r);
        check(r == 16'hABCD, "R9 no commit on abort", r, 16'hABCD);

        access(1, 1, 17'h45, 1, 16'hFFFF, 2'd0, n, r);
        access(0, 1, 17'h44, 0, 16'h0, 2'd0, n, r);
        check(r == 16'h0, "R6 no lanes enabled", r, 0);

        access(1, 1, 17'h7E, 0, 16'h9A3C, 2'd0, n, r);
        access(0, 1, 17'h7E, 0, 16'h0, 2'd2, n, r);
        check(r == 16'h9A3C, "R10 committed at release", r, 16'h9A3C);

        repeat (4) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule